// File: doc/BRIEF.md
# SPI Flash Memory-Window Read Engine

This block turns a read of a memory window into a complete SPI flash read transaction. A requester places a byte offset on a simple valid/ready bus. The engine then selects the flash device that the routing input names and looks up that device's setup word. It runs the command sequence the setup word describes: a one-line opcode, a one-line address, idle dummy bytes, and a data phase on one, two or four lines. It returns one 32-bit word.

Each chip select has its own 14-bit setup word, loaded through a small write port. The setup word holds the opcode, the address length, the dummy length and the data line width, so one word fully defines the command. A mode-enable input acts as a switch that gives the pins to the window path. While the switch is clear, window requests are refused at once with an error flag and the pins are left to the register-command path. SCLK runs in SPI mode 0 and its speed is set by a parameter.

Top module: `sfr_mmap_reader`

## Requirements
- R1: While reset is asserted, and after it is released with no request pending, every chip select is high, SCLK is low, all `io_oe` bits are 0 and `req_ready` is 0. A reset that arrives during a transaction deasserts chip select at once.
- R2: Each transaction starts with 8 SCLK cycles carrying the opcode, setup bits 7:0, MSB first on `io_out[0]` with `io_oe` = 4'b0001.
- R3: The address phase lasts (setup bits 9:8 + 1) bytes, from 1 to 4. It carries the low bytes of `req_addr`, zero-extended to 32 bits, MSB first on `io_out[0]` with `io_oe` = 4'b0001.
- R4: After the address come (setup bits 11:10) dummy bytes of 8 SCLK cycles each, with `io_oe` = 0. Zero dummy bytes skips the phase.
- R5: The data phase width is set by setup bits 13:12. A value of 0 (or 2) reads one line, `io_in[1]`, for 32 cycles. A value of 1 reads two lines, {`io_in[1]`,`io_in[0]`}, for 16 cycles. A value of 3 reads four lines, `io_in[3:0]`, for 8 cycles. The higher-numbered line carries the earlier bit, and `io_oe` stays 0 throughout the data phase.
- R6: Received bits are MSB first within each byte. The first byte received lands in `rsp_data[7:0]` and the fourth in `rsp_data[31:24]`.
- R7: A completed read raises `req_ready` for exactly one cycle, with `rsp_err` = 0 and the word on `rsp_data`. All chip selects are already high in that cycle.
- R8: A request while `mm_en` = 0 is answered in the next cycle with `req_ready` = 1, `rsp_err` = 1 and `rsp_data` = 0. No chip select falls and SCLK does not toggle.
- R9: A `cs_route` value k in 1..NCS drives only `cs_n[k-1]` low. A value of 0, or any value above NCS, is refused exactly as in R8.
- R10: Writing `cfg_data` with `cfg_we` = 1 updates only the setup word of the chip select given by `cfg_idx`. The reset value is opcode 8'h03, three address bytes, no dummy, single line.
- R11: SCLK idles low, and one period lasts 2×HALF clock cycles. Outputs change on the falling edge and inputs are sampled on the rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mm_en | input | 1 | Memory-window mode switch |
| cs_route | input | 3 | Target device, chip select n encoded as n+1, 0 = none |
| cfg_we | input | 1 | Setup word write strobe |
| cfg_idx | input | IDX_W | Chip select whose setup word is written |
| cfg_data | input | 14 | Setup word: mode 13:12, dummy 11:10, address bytes-1 9:8, opcode 7:0 |
| req_valid | input | 1 | Read request valid, held until `req_ready` |
| req_addr | input | ADDR_W | Byte offset inside the window |
| req_ready | output | 1 | One-cycle completion strobe |
| rsp_data | output | 32 | Read word (zero on error) |
| rsp_err | output | 1 | Request refused |
| sclk | output | 1 | SPI clock |
| cs_n | output | NCS | Active-low chip selects |
| io_out | output | 4 | Data line output values |
| io_oe | output | 4 | Data line output enables |
| io_in | input | 4 | Data line input values |

## Verification
The assertions assume that a requester keeps `req_valid` and `req_addr` steady until `req_ready` and drops `req_valid` in the strobe cycle. They also assume that setup words and `cs_route` do not change while a read is in flight. The bench drives every input on the falling clock edge and lowers `req_valid` in the strobe cycle. It reprograms setup words only between requests, and it models the flash from SCLK edges seen on the falling clock edge, so the data lines settle well before the next SCLK rise.

// File: rtl/sfr_pkg.sv
package sfr_pkg;

  localparam int SETUP_W = 14;

  // Field order fixes the bit positions: opcode 7:0, addr_bytes_m1 9:8,
  // dummy_bytes 11:10, rmode 13:12.
  typedef struct packed {
    logic [1:0] rmode;
    logic [1:0] dummy_bytes;
    logic [1:0] addr_bytes_m1;
    logic [7:0] opcode;
  } sfr_setup_t;

  typedef enum logic [1:0] {
    PH_CMD   = 2'd0,
    PH_ADDR  = 2'd1,
    PH_DUMMY = 2'd2,
    PH_DATA  = 2'd3
  } sfr_phase_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_DONE = 2'd2
  } sfr_state_e;

  localparam sfr_setup_t SETUP_RST = '{rmode: 2'd0, dummy_bytes: 2'd0,
                                      addr_bytes_m1: 2'd2, opcode: 8'h03};

  function automatic logic [2:0] lanes_of(input logic [1:0] m);
    case (m)
      2'd1:    return 3'd2;
      2'd3:    return 3'd4;
      default: return 3'd1;
    endcase
  endfunction

endpackage

// File: rtl/sfr_setup_bank.sv
module sfr_setup_bank
  import sfr_pkg::*;
#(
  parameter  int NCS   = 4,
  localparam int IDX_W = (NCS > 1) ? $clog2(NCS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  sfr_setup_t       wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output sfr_setup_t       rd_setup
);

  sfr_setup_t ent_arr [NCS];

  generate
    for (genvar g = 0; g < NCS; g++) begin : g_ent
      sfr_setup_t ent_q;
      logic       hit;
      assign hit = wr_en && (wr_idx == IDX_W'(g));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   ent_q <= SETUP_RST;
        else if (hit) ent_q <= wr_data;
      end
      assign ent_arr[g] = ent_q;
    end
  endgenerate

  always_comb begin
    if (32'(rd_idx) < NCS) rd_setup = ent_arr[rd_idx];
    else                   rd_setup = SETUP_RST;
  end

endmodule

// File: rtl/sfr_sclk_gen.sv
module sfr_sclk_gen #(
  parameter  int HALF = 2,
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sclk,
  output logic rise_tick,
  output logic fall_tick
);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          sclk_q, sclk_d;
  logic          wrap;

  assign wrap      = run && (cnt_q == CW'(HALF - 1));
  assign rise_tick = wrap && !sclk_q;
  assign fall_tick = wrap &&  sclk_q;
  assign sclk      = sclk_q;

  always_comb begin
    cnt_d  = cnt_q;
    sclk_d = sclk_q;
    if (!run) begin
      cnt_d  = '0;
      sclk_d = 1'b0;
    end else if (wrap) begin
      cnt_d  = '0;
      sclk_d = !sclk_q;
    end else begin
      cnt_d  = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      sclk_q <= sclk_d;
    end
  end

  AST_SCLK_PARK: assert property (@(posedge clk) disable iff (!rst_n) !run |=> !sclk);  // R11

endmodule

// File: rtl/sfr_read_seq.sv
module sfr_read_seq
  import sfr_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  sfr_setup_t        setup,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rise_tick,
  input  logic              fall_tick,
  input  logic [3:0]        io_in,
  output logic              active,
  output logic              done,
  output logic [31:0]       word,
  output logic [3:0]        io_out,
  output logic [3:0]        io_oe
);

  localparam int OUT_W = 8 + 32;

  logic             act_q, act_d;
  logic             done_q, done_d;
  sfr_phase_e       ph_q, ph_d;
  logic [5:0]       left_q, left_d;
  logic [OUT_W-1:0] sho_q, sho_d;
  logic [31:0]      shi_q, shi_d;
  logic [2:0]       lanes_q, lanes_d;
  logic [1:0]       dmy_q, dmy_d;
  logic [1:0]       ab_q, ab_d;

  logic [31:0] addr32;
  logic [4:0]  ash;
  logic [5:0]  data_len;

  assign addr32 = 32'(addr);
  assign ash    = {(2'd3 - setup.addr_bytes_m1), 3'b000};

  always_comb begin
    case (lanes_q)
      3'd4:    data_len = 6'd8;
      3'd2:    data_len = 6'd16;
      default: data_len = 6'd32;
    endcase
  end

  always_comb begin
    act_d   = act_q;
    done_d  = 1'b0;
    ph_d    = ph_q;
    left_d  = left_q;
    sho_d   = sho_q;
    shi_d   = shi_q;
    lanes_d = lanes_q;
    dmy_d   = dmy_q;
    ab_d    = ab_q;
    if (start && !act_q) begin
      act_d   = 1'b1;
      ph_d    = PH_CMD;
      left_d  = 6'd8;
      sho_d   = {setup.opcode, addr32 << ash};
      shi_d   = '0;
      lanes_d = lanes_of(setup.rmode);
      dmy_d   = setup.dummy_bytes;
      ab_d    = setup.addr_bytes_m1;
    end else if (act_q) begin
      if (rise_tick && ph_q == PH_DATA) begin
        case (lanes_q)
          3'd4:    shi_d = {shi_q[27:0], io_in};
          3'd2:    shi_d = {shi_q[29:0], io_in[1:0]};
          default: shi_d = {shi_q[30:0], io_in[1]};
        endcase
      end
      if (fall_tick) begin
        if (ph_q == PH_CMD || ph_q == PH_ADDR) sho_d = sho_q << 1;
        if (left_q == 6'd1) begin
          case (ph_q)
            PH_CMD: begin
              ph_d   = PH_ADDR;
              left_d = {({1'b0, ab_q} + 3'd1), 3'b000};
            end
            PH_ADDR: begin
              if (dmy_q != 2'd0) begin
                ph_d   = PH_DUMMY;
                left_d = {1'b0, dmy_q, 3'b000};
              end else begin
                ph_d   = PH_DATA;
                left_d = data_len;
              end
            end
            PH_DUMMY: begin
              ph_d   = PH_DATA;
              left_d = data_len;
            end
            default: begin
              act_d  = 1'b0;
              done_d = 1'b1;
            end
          endcase
        end else begin
          left_d = left_q - 6'd1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      done_q  <= 1'b0;
      ph_q    <= PH_CMD;
      left_q  <= '0;
      sho_q   <= '0;
      shi_q   <= '0;
      lanes_q <= 3'd1;
      dmy_q   <= '0;
      ab_q    <= '0;
    end else begin
      act_q   <= act_d;
      done_q  <= done_d;
      ph_q    <= ph_d;
      left_q  <= left_d;
      sho_q   <= sho_d;
      shi_q   <= shi_d;
      lanes_q <= lanes_d;
      dmy_q   <= dmy_d;
      ab_q    <= ab_d;
    end
  end

  assign active = act_q;
  assign done   = done_q;
  assign word   = {shi_q[7:0], shi_q[15:8], shi_q[23:16], shi_q[31:24]};
  assign io_out = {3'b000, sho_q[OUT_W-1]};
  assign io_oe  = (act_q && (ph_q == PH_CMD || ph_q == PH_ADDR)) ? 4'b0001 : 4'b0000;

  AST_CMD_FIRST: assert property (@(posedge clk) disable iff (!rst_n) $rose(act_q) |-> ph_q == PH_CMD);  // R2
  AST_DATA_LAST: assert property (@(posedge clk) disable iff (!rst_n) (act_q && ph_q == PH_DATA) |=> (!act_q || ph_q == PH_DATA));  // R5
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) done_q |-> !act_q);  // R7

endmodule

// File: rtl/sfr_mmap_reader.sv
module sfr_mmap_reader
  import sfr_pkg::*;
#(
  parameter  int NCS    = 4,
  parameter  int ADDR_W = 24,
  parameter  int HALF   = 2,
  localparam int IDX_W  = (NCS > 1) ? $clog2(NCS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mm_en,
  input  logic [2:0]        cs_route,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [13:0]       cfg_data,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic [31:0]       rsp_data,
  output logic              rsp_err,
  output logic              sclk,
  output logic [NCS-1:0]    cs_n,
  output logic [3:0]        io_out,
  output logic [3:0]        io_oe,
  input  logic [3:0]        io_in
);

  localparam logic [3:0] NCS_L = 4'(NCS);

  sfr_state_e       st_q, st_d;
  logic [IDX_W-1:0] sel_q, sel_d;
  logic [31:0]      data_q, data_d;
  logic             err_q, err_d;

  logic             route_ok;
  logic [IDX_W-1:0] route_idx;
  logic             go;
  sfr_setup_t       cur_setup;
  logic             seq_active, seq_done;
  logic [31:0]      seq_word;
  logic             rise_tick, fall_tick;

  assign route_ok  = (cs_route != 3'd0) && ({1'b0, cs_route} <= NCS_L);
  assign route_idx = IDX_W'(cs_route - 3'd1);
  assign go        = (st_q == ST_IDLE) && req_valid && mm_en && route_ok;

  sfr_setup_bank #(.NCS(NCS)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cfg_we),
    .wr_idx   (cfg_idx),
    .wr_data  (sfr_setup_t'(cfg_data)),
    .rd_idx   (route_idx),
    .rd_setup (cur_setup)
  );

  sfr_sclk_gen #(.HALF(HALF)) u_clk (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (seq_active),
    .sclk      (sclk),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick)
  );

  sfr_read_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (go),
    .setup     (cur_setup),
    .addr      (req_addr),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick),
    .io_in     (io_in),
    .active    (seq_active),
    .done      (seq_done),
    .word      (seq_word),
    .io_out    (io_out),
    .io_oe     (io_oe)
  );

  always_comb begin
    st_d   = st_q;
    sel_d  = sel_q;
    data_d = data_q;
    err_d  = err_q;
    case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          if (mm_en && route_ok) begin
            st_d  = ST_XFER;
            sel_d = route_idx;
          end else begin
            st_d   = ST_DONE;
            err_d  = 1'b1;
            data_d = '0;
          end
        end
      end
      ST_XFER: begin
        if (seq_done) begin
          st_d   = ST_DONE;
          err_d  = 1'b0;
          data_d = seq_word;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      sel_q  <= '0;
      data_q <= '0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      sel_q  <= sel_d;
      data_q <= data_d;
      err_q  <= err_d;
    end
  end

  generate
    for (genvar g = 0; g < NCS; g++) begin : g_cs
      assign cs_n[g] = !((st_q == ST_XFER) && (sel_q == IDX_W'(g)));
    end
  endgenerate

  assign req_ready = (st_q == ST_DONE);
  assign rsp_data  = data_q;
  assign rsp_err   = err_q;

  AST_ONE_CS:      assert property (@(posedge clk) disable iff (!rst_n) $onehot0(~cs_n));  // R9
  AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n) req_ready |=> !req_ready);  // R7
  AST_ERR_ZERO:    assert property (@(posedge clk) disable iff (!rst_n) (req_ready && rsp_err) |-> rsp_data == 32'd0);  // R8
  AST_OFF_NO_CS:   assert property (@(posedge clk) disable iff (!rst_n) (st_q == ST_IDLE && req_valid && !mm_en) |=> (&cs_n));  // R8
  AST_SCLK_IN_CS:  assert property (@(posedge clk) disable iff (!rst_n) sclk |-> !(&cs_n));  // R11
  AST_OE_IN_CS:    assert property (@(posedge clk) disable iff (!rst_n) (io_oe != 4'd0) |-> !(&cs_n));  // R4
  AST_DONE_CS_UP:  assert property (@(posedge clk) disable iff (!rst_n) req_ready |-> (&cs_n));  // R7

endmodule

// File: tb/sim_sfr_mmap_reader.sv
module sim_sfr_mmap_reader;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        mm_en;
  logic [2:0]  cs_route;
  logic        cfg_we;
  logic [1:0]  cfg_idx;
  logic [13:0] cfg_data;
  logic        req_valid;
  logic [23:0] req_addr;
  logic        req_ready;
  logic [31:0] rsp_data;
  logic        rsp_err;
  logic        sclk;
  logic [3:0]  cs_n;
  logic [3:0]  io_out, io_oe;
  logic [3:0]  io_in;

  always #10 clk = ~clk;

  sfr_mmap_reader #(.NCS(4), .ADDR_W(24), .HALF(2)) u0 (
    .clk(clk), .rst_n(rst_n), .mm_en(mm_en), .cs_route(cs_route),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_data(cfg_data),
    .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
    .rsp_data(rsp_data), .rsp_err(rsp_err), .sclk(sclk), .cs_n(cs_n),
    .io_out(io_out), .io_oe(io_oe), .io_in(io_in)
  );

  int total = 0;
  int bad   = 0;
  bit ended = 0;

  // flash model configuration (set by the bench) and observations
  int          m_lanes = 1, m_ab = 3, m_dm = 0;
  logic [31:0] m_data = '0;
  int          rcnt = 0, rises = 0, any_rise = 0, oe_bad = 0;
  logic [7:0]  cap_op = '0;
  logic [31:0] cap_addr = '0;
  logic [3:0]  cs_seen = '0;
  int          clkn = 0, last_rise = -1, per_min = 1000, per_max = 0;
  logic        sp = 1'b0;

  function automatic logic sbit(input logic [31:0] d, input int k);
    return d[8 * (k / 8) + 7 - (k % 8)];
  endfunction

  always @(negedge clk) begin
    int pre_a, pre, j;
    clkn++;
    pre_a = 8 + 8 * m_ab;
    pre   = pre_a + 8 * m_dm;
    if (sclk && !sp) any_rise++;
    if (&cs_n) begin
      rcnt = 0;
    end else begin
      cs_seen |= ~cs_n;
      if (sclk && !sp) begin
        if (rcnt < 8) begin
          cap_op = {cap_op[6:0], io_out[0]};
          if (io_oe != 4'b0001) oe_bad++;
        end else if (rcnt < pre_a) begin
          cap_addr = {cap_addr[30:0], io_out[0]};
          if (io_oe != 4'b0001) oe_bad++;
        end else if (io_oe != 4'b0000) begin
          oe_bad++;
        end
        if (last_rise >= 0) begin
          if (clkn - last_rise < per_min) per_min = clkn - last_rise;
          if (clkn - last_rise > per_max) per_max = clkn - last_rise;
        end
        last_rise = clkn;
        rises++;
        rcnt++;
      end else if (!sclk && sp && rcnt >= pre) begin
        j = rcnt - pre;
        if (m_lanes == 1) io_in[1] = sbit(m_data, j);
        else begin
          for (int i = 0; i < m_lanes; i++)
            io_in[m_lanes - 1 - i] = sbit(m_data, j * m_lanes + i);
        end
      end
    end
    sp = sclk;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_setup(input int idx, input logic [7:0] op, input logic [1:0] abm1,
                          input logic [1:0] dm, input logic [1:0] md);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 2'(idx); cfg_data = {md, dm, abm1, op};
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_model(input logic [1:0] abm1, input logic [1:0] dm,
                           input logic [1:0] md, input logic [31:0] d);
    m_ab = int'(abm1) + 1;
    m_dm = int'(dm);
    m_lanes = (md == 2'd3) ? 4 : (md == 2'd1) ? 2 : 1;
    m_data = d;
  endtask

  logic [31:0] r_data;
  logic        r_err, r_rdy_after;
  logic [3:0]  r_cs;

  task automatic do_req(input logic [2:0] route, input logic [23:0] a);
    int n;
    @(negedge clk);
    rises = 0; any_rise = 0; oe_bad = 0; cs_seen = '0; cap_op = '0; cap_addr = '0;
    last_rise = -1; per_min = 1000; per_max = 0;
    cs_route = route; req_addr = a; req_valid = 1'b1;
    n = 0;
    while (!req_ready && n < 5000) begin
      @(negedge clk);
      n++;
    end
    r_data = rsp_data; r_err = rsp_err; r_cs = cs_n;
    req_valid = 1'b0;
    @(negedge clk);
    r_rdy_after = req_ready;
  endtask

  // route, opcode, addr_bytes_m1, dummy, mode, address, data
  localparam int NV = 7;
  localparam logic [80:0] VECS [NV] = '{
    {3'd1, 8'h03, 2'd2, 2'd0, 2'd0, 32'h00123456, 32'hA1B2C3D4},
    {3'd2, 8'h3B, 2'd2, 2'd1, 2'd1, 32'h00ABCDEF, 32'h5A6B7C8D},
    {3'd3, 8'h6B, 2'd3, 2'd1, 2'd3, 32'h00FEDCBA, 32'h89ABCDEF},
    {3'd4, 8'hEB, 2'd0, 2'd3, 2'd3, 32'h000000C5, 32'h01234567},
    {3'd1, 8'h0B, 2'd1, 2'd2, 2'd0, 32'h0000BEEF, 32'hFFFF0000},
    {3'd2, 8'h3B, 2'd2, 2'd0, 2'd1, 32'h00FFFFFF, 32'h80000001},
    {3'd3, 8'h13, 2'd3, 2'd0, 2'd2, 32'h007FFFFF, 32'hC3A5965A}
  };

  initial begin
    int n;
    rst_n = 1'b0; mm_en = 1'b0; cs_route = 3'd0; cfg_we = 1'b0; cfg_idx = '0;
    cfg_data = '0; req_valid = 1'b0; req_addr = '0; io_in = 4'b0;
    repeat (3) @(negedge clk);
    chk(cs_n == 4'hF && !sclk && io_oe == 4'h0 && !req_ready, "R1 in reset",
        {cs_n, 3'b0, sclk, io_oe, 3'b0, req_ready}, 32'hF0000000);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(cs_n == 4'hF && !sclk && io_oe == 4'h0 && !req_ready, "R1 after reset",
        {cs_n, 3'b0, sclk, io_oe, 3'b0, req_ready}, 32'hF0000000);

    // R8: switch clear, request refused
    set_model(2'd2, 2'd0, 2'd0, 32'h0);
    do_req(3'd1, 24'h000100);
    chk(r_err == 1'b1, "R8 err flag", {31'b0, r_err}, 32'd1);
    chk(r_data == 32'd0, "R8 zero data", r_data, 32'd0);
    chk(cs_seen == 4'd0 && any_rise == 0, "R8 no bus activity", {cs_seen, 28'(any_rise)}, 32'd0);

    mm_en = 1'b1;
    // R9: route 0 and out-of-range route refused
    do_req(3'd0, 24'h000100);
    chk(r_err && r_data == 0 && cs_seen == 0, "R9 route zero", {r_err, 27'b0, cs_seen}, 32'h80000000);
    do_req(3'd5, 24'h000100);
    chk(r_err && r_data == 0 && cs_seen == 0, "R9 route above NCS", {r_err, 27'b0, cs_seen}, 32'h80000000);

    // R10: reset value of a setup word (opcode 03, 3 addr bytes, single)
    set_model(2'd2, 2'd0, 2'd0, 32'h11223344);
    do_req(3'd4, 24'h0A0B0C);
    chk(cap_op == 8'h03 && cap_addr[23:0] == 24'h0A0B0C, "R10 reset setup",
        {cap_op, cap_addr[23:0]}, 32'h030A0B0C);
    chk(r_data == 32'h11223344, "R6 default read data", r_data, 32'h11223344);

    // table walk
    for (int v = 0; v < NV; v++) begin
      logic [80:0] e;
      logic [31:0] amask;
      int exp_rises;
      e = VECS[v];
      wr_setup(int'(e[80:78]) - 1, e[77:70], e[69:68], e[67:66], e[65:64]);
      set_model(e[69:68], e[67:66], e[65:64], e[31:0]);
      amask = 32'((64'd1 << (8 * m_ab)) - 64'd1);
      exp_rises = 8 + 8 * m_ab + 8 * m_dm + 32 / m_lanes;
      do_req(e[80:78], e[55:32]);
      chk(r_data == e[31:0], "R6 R5 word", r_data, e[31:0]);
      chk(r_err == 1'b0, "R7 no error", {31'b0, r_err}, 32'd0);
      chk(r_cs == 4'hF, "R7 cs high at ready", {28'b0, r_cs}, 32'hF);
      chk(r_rdy_after == 1'b0, "R7 one-cycle ready", {31'b0, r_rdy_after}, 32'd0);
      chk(cap_op == e[77:70], "R2 opcode", {24'b0, cap_op}, {24'b0, e[77:70]});
      chk((cap_addr & amask) == (e[63:32] & amask), "R3 address", cap_addr & amask, e[63:32] & amask);
      chk(rises == exp_rises, "R4 R5 sclk count", 32'(rises), 32'(exp_rises));
      chk(oe_bad == 0, "R4 line enables", 32'(oe_bad), 32'd0);
      chk(cs_seen == 4'(1 << (int'(e[80:78]) - 1)), "R9 selected line", {28'b0, cs_seen},
          32'(1 << (int'(e[80:78]) - 1)));
      chk(per_min == 4 && per_max == 4, "R11 sclk period", {16'(per_min), 16'(per_max)}, 32'h00040004);
    end

    // R10: writes to one chip select leave another untouched
    wr_setup(1, 8'h9F, 2'd2, 2'd0, 2'd0);
    wr_setup(2, 8'h5A, 2'd0, 2'd0, 2'd3);
    set_model(2'd2, 2'd0, 2'd0, 32'hDEADBEEF);
    do_req(3'd2, 24'h000001);
    chk(cap_op == 8'h9F, "R10 setup kept per chip select", {24'b0, cap_op}, 32'h9F);
    chk(r_data == 32'hDEADBEEF, "R10 read after neighbour write", r_data, 32'hDEADBEEF);

    // R1: reset in the middle of a read
    set_model(2'd2, 2'd0, 2'd0, 32'h0);
    @(negedge clk);
    cs_route = 3'd1; req_addr = 24'h000010; req_valid = 1'b1;
    repeat (20) @(negedge clk);
    chk(cs_n != 4'hF, "R1 read in flight", {28'b0, cs_n}, 32'hE);
    rst_n = 1'b0;
    #1;
    chk(cs_n == 4'hF && !sclk && io_oe == 0, "R1 async reset mid read", {28'b0, cs_n}, 32'hF);
    req_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(cs_n == 4'hF && !req_ready, "R1 idle after reset", {28'b0, cs_n}, 32'hF);

    if (!ended) begin
      ended = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(negedge clk);
    if (!ended) begin
      ended = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule